// File: doc/BRIEF.md
# Serially Configured Test-Socket Pin Driver

This block lets a host controller with few free I/O lines run a 14-pin logic device under test. Seven control lines come in from the host: serial data, a shift clock, three latch strobes, a global output enable and a synchronous reset. A single shift register collects every serial word. Each strobe copies that word into one of three holding registers. The direction register decides which socket pins are driven. The value register gives the level on each driven pin. The select register holds the index of the pin whose level comes back to the host.

Each socket pin has a drive value and a tri-state enable. A pin with its direction bit set feeds an input of the device and is driven. A pin with its direction bit clear is an output of the device and is left floating, so the device can drive it. One return line carries the sampled level of the selected pin back to the host. The host works in this order: set the directions, apply the values, select a pin, then read it.

All control lines are sampled on the block's own clock, and a rising edge on the shift clock or on a strobe is treated as an event. The holding registers change only on their strobe, so the pins stay steady while new words are shifted in.

Top module: `serial_pin_driver`

## Requirements
- R1: While sync_rst is high at a clk edge, every register in the block clears. After that edge pin_oe, pin_out and ret_level are all 0.
- R2: The control lines are registered on clk. A rising edge seen on ser_clk shifts the registered ser_data into bit 0 of a 14-bit shift register, and every older bit moves up one position toward bit 13. After 14 shifts, the first bit sent sits in bit 13.
- R3: A rising edge on dir_stb copies the whole shift register into the direction register, where bit i belongs to pin i and 1 means driven. Holding dir_stb high latches only once. The direction register changes only on such an edge.
- R4: A rising edge on val_stb copies the shift register into the value register. A rising edge on sel_stb copies shift register bits [3:0] into the select register.
- R5: While out_en is high, pin_oe[i] equals direction bit i, and pin_out[i] equals value bit i AND direction bit i. The outputs reach the ports one clk after a latch or after an out_en change is registered.
- R6: After out_en is seen low, pin_oe and pin_out are all 0 from the next clk on, and every pin floats.
- R7: ret_level carries pin_in[sel], sampled through one register and driven out of a second. A select value of 14 or 15 gives ret_level = 0.
- R8: When a shift event and a strobe event fall in the same cycle, the strobe latches the shift register contents from before that shift.
- R9: Shifting without a strobe leaves pin_oe, pin_out and the selected pin unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to sample all control lines |
| sync_rst | input | 1 | Synchronous active-high reset from the host |
| ser_data | input | 1 | Serial data bit |
| ser_clk | input | 1 | Shift clock from the host; a rising edge shifts one bit |
| dir_stb | input | 1 | Direction latch strobe |
| val_stb | input | 1 | Drive value latch strobe |
| sel_stb | input | 1 | Return-pin select latch strobe |
| out_en | input | 1 | Global enable for all pin drivers |
| pin_in | input | 14 | Sensed level of each socket pin |
| pin_oe | output | 14 | Tri-state enable per pin; 1 means driven |
| pin_out | output | 14 | Drive level per pin; 0 on pins that are not driven |
| ret_level | output | 1 | Level of the selected pin returned to the host |

## Verification
The cycles that matter are the ones where a shift event and a latch event land together. The strobe must then take the word as it stood before the shift, while the shift still moves the register on. The bench raises ser_clk and dir_stb at the same clock edge on top of a known word. It checks that the driven pins show the old word, and that a second, lone strobe then shows the shifted word. It also holds a strobe high across a whole new serial load and checks that the pins do not move.

// File: rtl/spd_pkg.sv
package spd_pkg;

  // Control lines as seen after the input register stage
  typedef struct packed {
    logic sclk;
    logic sdat;
    logic dir_stb;
    logic val_stb;
    logic sel_stb;
    logic oe;
  } ctl_t;

  // One-cycle events derived from rising edges
  typedef struct packed {
    logic shift;
    logic dir_ld;
    logic val_ld;
    logic sel_ld;
  } evt_t;

  localparam int EDGE_N = 4;

endpackage

// File: rtl/spd_ctl_sampler.sv
module spd_ctl_sampler
  import spd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  ctl_t ctl_in,
  output logic sdat_q,
  output logic oe_q,
  output evt_t evt
);

  ctl_t              q1;
  logic [EDGE_N-1:0] lvl_q1;
  logic [EDGE_N-1:0] lvl_q2;
  logic [EDGE_N-1:0] rise;

  // First stage: register every host line on the block clock
  always_ff @(posedge clk) begin
    if (rst) q1 <= '0;
    else     q1 <= ctl_in;
  end

  assign lvl_q1 = {q1.sclk, q1.dir_stb, q1.val_stb, q1.sel_stb};

  // Second stage holds the previous level for edge detection
  always_ff @(posedge clk) begin
    if (rst) lvl_q2 <= '0;
    else     lvl_q2 <= lvl_q1;
  end

  genvar g;
  generate
    for (g = 0; g < EDGE_N; g++) begin : g_edge
      assign rise[g] = lvl_q1[g] & ~lvl_q2[g];
    end
  endgenerate

  assign evt.shift  = rise[3];
  assign evt.dir_ld = rise[2];
  assign evt.val_ld = rise[1];
  assign evt.sel_ld = rise[0];
  assign sdat_q     = q1.sdat;
  assign oe_q       = q1.oe;

endmodule

// File: rtl/spd_shift_chain.sv
module spd_shift_chain #(
  parameter int WIDTH = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift,
  input  logic             din,
  output logic [WIDTH-1:0] sr
);

  // New bit enters at bit 0, older bits move toward the top
  always_ff @(posedge clk) begin
    if (rst)        sr <= '0;
    else if (shift) sr <= {sr[WIDTH-2:0], din};
  end

endmodule

// File: rtl/spd_latch_bank.sv
module spd_latch_bank
  import spd_pkg::*;
#(
  parameter int WIDTH = 14,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  evt_t             evt,
  input  logic [WIDTH-1:0] sr,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] val_q,
  output logic [SEL_W-1:0] sel_q
);

  // Each register reads the shift register value present before this
  // edge, so a shift in the same cycle does not reach the latched word.
  always_ff @(posedge clk) begin
    if (rst)             dir_q <= '0;
    else if (evt.dir_ld) dir_q <= sr;
  end

  always_ff @(posedge clk) begin
    if (rst)             val_q <= '0;
    else if (evt.val_ld) val_q <= sr;
  end

  always_ff @(posedge clk) begin
    if (rst)             sel_q <= '0;
    else if (evt.sel_ld) sel_q <= sr[SEL_W-1:0];
  end

endmodule

// File: rtl/spd_pin_stage.sv
module spd_pin_stage #(
  parameter int WIDTH = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             oe,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] val_q,
  output logic [WIDTH-1:0] pin_oe,
  output logic [WIDTH-1:0] pin_out
);

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_pin
      // Registered enable and level per socket pin
      always_ff @(posedge clk) begin
        if (rst) begin
          pin_oe[i]  <= 1'b0;
          pin_out[i] <= 1'b0;
        end else begin
          pin_oe[i]  <= oe & dir_q[i];
          pin_out[i] <= oe & dir_q[i] & val_q[i];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/spd_return_mux.sv
module spd_return_mux #(
  parameter int WIDTH = 14,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin_in,
  input  logic [SEL_W-1:0] sel,
  output logic             ret
);

  logic [WIDTH-1:0] pin_q;
  logic             pick;

  always_ff @(posedge clk) begin
    if (rst) pin_q <= '0;
    else     pin_q <= pin_in;
  end

  // Indices with no pin behind them leave pick at 0
  always_comb begin
    pick = 1'b0;
    for (int k = 0; k < WIDTH; k++) begin
      if (sel == SEL_W'(k)) pick = pin_q[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ret <= 1'b0;
    else     ret <= pick;
  end

endmodule

// File: rtl/serial_pin_driver.sv
module serial_pin_driver
  import spd_pkg::*;
#(
  parameter int PIN_COUNT = 14,
  localparam int SEL_W    = $clog2(PIN_COUNT)
) (
  input  logic                 clk,
  input  logic                 sync_rst,
  input  logic                 ser_data,
  input  logic                 ser_clk,
  input  logic                 dir_stb,
  input  logic                 val_stb,
  input  logic                 sel_stb,
  input  logic                 out_en,
  input  logic [PIN_COUNT-1:0] pin_in,
  output logic [PIN_COUNT-1:0] pin_oe,
  output logic [PIN_COUNT-1:0] pin_out,
  output logic                 ret_level
);

  ctl_t                 ctl_raw;
  evt_t                 evt;
  logic                 sdat_q;
  logic                 oe_q;
  logic                 shift_ev;
  logic                 dir_ld;
  logic [PIN_COUNT-1:0] sr_q;
  logic [PIN_COUNT-1:0] dir_q;
  logic [PIN_COUNT-1:0] val_q;
  logic [SEL_W-1:0]     sel_q;

  assign ctl_raw.sclk    = ser_clk;
  assign ctl_raw.sdat    = ser_data;
  assign ctl_raw.dir_stb = dir_stb;
  assign ctl_raw.val_stb = val_stb;
  assign ctl_raw.sel_stb = sel_stb;
  assign ctl_raw.oe      = out_en;

  assign shift_ev = evt.shift;
  assign dir_ld   = evt.dir_ld;

  spd_ctl_sampler u_sampler (
    .clk    (clk),
    .rst    (sync_rst),
    .ctl_in (ctl_raw),
    .sdat_q (sdat_q),
    .oe_q   (oe_q),
    .evt    (evt)
  );

  spd_shift_chain #(.WIDTH(PIN_COUNT)) u_shift (
    .clk   (clk),
    .rst   (sync_rst),
    .shift (shift_ev),
    .din   (sdat_q),
    .sr    (sr_q)
  );

  spd_latch_bank #(.WIDTH(PIN_COUNT), .SEL_W(SEL_W)) u_latch (
    .clk   (clk),
    .rst   (sync_rst),
    .evt   (evt),
    .sr    (sr_q),
    .dir_q (dir_q),
    .val_q (val_q),
    .sel_q (sel_q)
  );

  spd_pin_stage #(.WIDTH(PIN_COUNT)) u_pins (
    .clk     (clk),
    .rst     (sync_rst),
    .oe      (oe_q),
    .dir_q   (dir_q),
    .val_q   (val_q),
    .pin_oe  (pin_oe),
    .pin_out (pin_out)
  );

  spd_return_mux #(.WIDTH(PIN_COUNT), .SEL_W(SEL_W)) u_ret (
    .clk    (clk),
    .rst    (sync_rst),
    .pin_in (pin_in),
    .sel    (sel_q),
    .ret    (ret_level)
  );

endmodule

// File: rtl/spd_chk.sv
module spd_chk #(
  parameter int PIN_COUNT = 14,
  parameter int SEL_W     = 4
) (
  input logic                 clk,
  input logic                 sync_rst,
  input logic [PIN_COUNT-1:0] pin_oe,
  input logic [PIN_COUNT-1:0] pin_out,
  input logic                 ret_level,
  input logic [PIN_COUNT-1:0] sr_q,
  input logic [PIN_COUNT-1:0] dir_q,
  input logic [SEL_W-1:0]     sel_q,
  input logic                 oe_q,
  input logic                 shift_ev,
  input logic                 dir_ld
);

  localparam logic [SEL_W:0] LIMIT = (SEL_W+1)'(PIN_COUNT);

  // R2: the shift register moves only on a shift event
  a_r2_shift_only_on_event: assert property (@(posedge clk) disable iff (sync_rst)
    !shift_ev |=> $stable(sr_q));

  // R3: the direction register moves only on its strobe
  a_r3_dir_held: assert property (@(posedge clk) disable iff (sync_rst)
    !dir_ld |=> $stable(dir_q));

  // R5: a driven level never appears on a floating pin
  a_r5_drive_within_enable: assert property (@(posedge clk) disable iff (sync_rst)
    (pin_out & ~pin_oe) == '0);

  // R5: with drivers enabled, the enables follow the direction register
  a_r5_oe_follows_dir: assert property (@(posedge clk) disable iff (sync_rst)
    oe_q |=> (pin_oe == $past(dir_q)));

  // R6: drivers disabled releases every pin
  a_r6_disable_floats: assert property (@(posedge clk) disable iff (sync_rst)
    !oe_q |=> (pin_oe == '0 && pin_out == '0));

  // R7: an index with no pin returns 0
  a_r7_high_sel_zero: assert property (@(posedge clk) disable iff (sync_rst)
    ({1'b0, sel_q} >= LIMIT) |=> !ret_level);

endmodule

bind serial_pin_driver spd_chk #(.PIN_COUNT(PIN_COUNT), .SEL_W(SEL_W)) u_chk (
  .clk       (clk),
  .sync_rst  (sync_rst),
  .pin_oe    (pin_oe),
  .pin_out   (pin_out),
  .ret_level (ret_level),
  .sr_q      (sr_q),
  .dir_q     (dir_q),
  .sel_q     (sel_q),
  .oe_q      (oe_q),
  .shift_ev  (shift_ev),
  .dir_ld    (dir_ld)
);

// File: tb/serial_pin_driver_tb.sv
module serial_pin_driver_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N = 14;

  logic clk = 1'b0;
  logic sync_rst = 1'b1;
  logic ser_data = 1'b0, ser_clk = 1'b0;
  logic dir_stb = 1'b0, val_stb = 1'b0, sel_stb = 1'b0, out_en = 1'b0;
  logic [N-1:0] pin_in = '0;
  logic [N-1:0] pin_oe, pin_out;
  logic ret_level;

  int compared = 0;
  int mismatched = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;
  string phase = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_pin_driver u_dut (
    .clk(clk), .sync_rst(sync_rst), .ser_data(ser_data), .ser_clk(ser_clk),
    .dir_stb(dir_stb), .val_stb(val_stb), .sel_stb(sel_stb), .out_en(out_en),
    .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out), .ret_level(ret_level)
  );

  // Behavioural reference: previous and current sampled line levels,
  // stored words, and the registered outputs the requirements call for.
  bit m_c1, m_c2, m_dat1, m_d1, m_d2, m_v1, m_v2, m_s1, m_s2, m_oe1;
  bit [N-1:0] m_sr, m_dir, m_val, m_pq, m_poe, m_pout;
  int m_sel;
  bit m_ret;

  always @(posedge clk) begin
    if (sync_rst) begin
      {m_c1, m_c2, m_dat1, m_d1, m_d2, m_v1, m_v2, m_s1, m_s2, m_oe1} = '0;
      m_sr = '0; m_dir = '0; m_val = '0; m_pq = '0; m_poe = '0; m_pout = '0;
      m_sel = 0; m_ret = 1'b0;
    end else begin
      m_poe  = m_oe1 ? m_dir : '0;
      m_pout = m_oe1 ? (m_dir & m_val) : '0;
      m_ret  = (m_sel < N) ? m_pq[m_sel] : 1'b0;
      m_pq   = pin_in;
      if (m_d1 && !m_d2) m_dir = m_sr;
      if (m_v1 && !m_v2) m_val = m_sr;
      if (m_s1 && !m_s2) m_sel = m_sr % 16;
      if (m_c1 && !m_c2) m_sr = (m_sr << 1) | N'(m_dat1);
      m_c2 = m_c1; m_d2 = m_d1; m_v2 = m_v1; m_s2 = m_s1;
      m_c1 = ser_clk; m_dat1 = ser_data; m_d1 = dir_stb; m_v1 = val_stb;
      m_s1 = sel_stb; m_oe1 = out_en;
    end
  end

  // Compare with the reference away from the active edge
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      compared++;
      if (pin_oe !== m_poe || pin_out !== m_pout || ret_level !== m_ret) begin
        mismatched++;
        $display("FAIL %s model: oe=%h out=%h ret=%b expected oe=%h out=%h ret=%b",
                 phase, pin_oe, pin_out, ret_level, m_poe, m_pout, m_ret);
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string tag, logic [N-1:0] got, logic [N-1:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // Send a word with the highest bit first; it ends up aligned in the register
  task automatic send_word(logic [N-1:0] w);
    for (int i = N-1; i >= 0; i--) begin
      ser_data = w[i]; ser_clk = 1'b1; tick();
      ser_clk = 1'b0; tick();
    end
  endtask

  task automatic pulse_dir(); dir_stb = 1'b1; tick(2); dir_stb = 1'b0; tick(4); endtask
  task automatic pulse_val(); val_stb = 1'b1; tick(2); val_stb = 1'b0; tick(4); endtask
  task automatic pulse_sel(); sel_stb = 1'b1; tick(2); sel_stb = 1'b0; tick(4); endtask

  initial begin
    tick(2);
    cmp_on = 1'b1;
    phase = "R1";
    check("R1 reset pin_oe", pin_oe, '0);
    check("R1 reset pin_out", pin_out, '0);
    check("R1 reset ret_level", N'(ret_level), '0);
    sync_rst = 1'b0;
    out_en = 1'b1;
    tick(2);

    phase = "R3";
    send_word(14'h0F0F); pulse_dir();
    check("R3 directions latched", pin_oe, 14'h0F0F);
    phase = "R4";
    send_word(14'h3333); pulse_val();
    check("R5 driven levels", pin_out, 14'h0303);

    phase = "R9";
    send_word(14'h3FFF);
    check("R9 oe unchanged by shift", pin_oe, 14'h0F0F);
    check("R9 out unchanged by shift", pin_out, 14'h0303);

    phase = "R6";
    out_en = 1'b0; tick(3);
    check("R6 disabled oe", pin_oe, '0);
    check("R6 disabled out", pin_out, '0);
    out_en = 1'b1; tick(3);
    check("R5 re-enabled oe", pin_oe, 14'h0F0F);

    phase = "R7";
    send_word(14'd5); pulse_sel();
    pin_in = 14'h0020; tick(3);
    check("R7 sel5 high", N'(ret_level), 14'd1);
    pin_in = 14'h3FDF; tick(3);
    check("R7 sel5 low", N'(ret_level), 14'd0);
    send_word(14'd13); pulse_sel();
    pin_in = 14'h2000; tick(3);
    check("R7 sel13 high", N'(ret_level), 14'd1);
    send_word(14'd0); pulse_sel();
    pin_in = 14'h0001; tick(3);
    check("R7 sel0 high", N'(ret_level), 14'd1);
    pin_in = 14'h3FFF;
    send_word(14'd14); pulse_sel(); tick(2);
    check("R7 sel14 zero", N'(ret_level), 14'd0);
    send_word(14'h3FFF); pulse_sel(); tick(2);
    check("R7 sel15 zero", N'(ret_level), 14'd0);

    phase = "R8";
    send_word(14'h1234);
    ser_data = 1'b1; ser_clk = 1'b1; dir_stb = 1'b1; tick(2);
    ser_clk = 1'b0; dir_stb = 1'b0; tick(4);
    check("R8 strobe takes pre-shift word", pin_oe, 14'h1234);
    pulse_dir();
    check("R8 later strobe takes shifted word", pin_oe, 14'h2469);

    phase = "R3";
    send_word(14'h0001);
    dir_stb = 1'b1; tick(4);
    check("R3 held strobe first latch", pin_oe, 14'h0001);
    send_word(14'h0002);
    check("R3 held strobe latches once", pin_oe, 14'h0001);
    dir_stb = 1'b0; tick(2);

    phase = "R2";
    send_word(14'h2AAA); pulse_dir();
    check("R2 shift order", pin_oe, 14'h2AAA);

    phase = "R1";
    sync_rst = 1'b1; tick();
    check("R1 mid-run reset oe", pin_oe, '0);
    check("R1 mid-run reset out", pin_out, '0);
    sync_rst = 1'b0; tick(4);
    check("R1 stays cleared", pin_oe, '0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      mismatched++;
      $display("FAIL watchdog run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule